// File: doc/BRIEF.md
# UART Receive-Line Idle Power Gate

This controller sits next to a UART receiver and keeps it unpowered while the receive line is held low, for instance when the cable is unplugged. The UART reports a break or a busy-detect condition when that happens. The controller then resets the UART, stops its clock and drops its request for the shared communication power domain. It also switches the RX pin over to plain input mode.

While the UART is powered down, the controller watches the pin for a rising edge and waits out a debounce window. It then brings the UART back up in a fixed order. First it requests power, then it enables the clock, then it resets the core and both FIFOs. It then holds a reprogramming window with RX still in plain input mode, so the UART cannot see a false busy condition. Only after that does it give the pin back to the UART.

A host open request runs the same power-up order at once. A host close request runs the power-down order without arming wake-up. The `wakePulse` and `active` outputs let the surrounding logic follow the sequence.

Top module: `rxidle_pwrgate`

## Requirements
- R1: While reset is asserted and after it is released, every output is low: `pdReq`, `clkEn`, `uartRst`, `rxMuxUart`, `cfgBusy`, `active` and `wakePulse`.
- R2: From the off state, `openReq` starts the power-up order, one step per clock. The steps are:
  - `pdReq` rises alone.
  - `clkEn` rises.
  - `uartRst` = 3'b111 for one cycle (bit 0 core, bit 1 RX FIFO, bit 2 TX FIFO).
  - `cfgBusy` is high for CFG_CYCLES cycles.
  - `rxMuxUart` and `active` rise together.
- R3: In the running state, `breakDet` starts the power-down order. First `uartRst` = 3'b111 with `clkEn` still high. Next cycle `clkEn` falls while the reset is still held. The cycle after, `pdReq`, `uartRst` and `active` go low together.
- R4: `busyDet` in the running state causes the same power-down order as `breakDet`, and it also arms wake-up.
- R5: `rxMuxUart` is 1 (pin driven to the UART) only in the running state. In every other state, including power-up and power-down, it is 0 (plain input).
- R6: After a break or busy power-down, `rxPin` must rise and stay high. `pdReq` then rises on the (CLK_KHZ*DEBOUNCE_MS + 3)-th clock edge after the pin rises. This count is two synchronizer stages, one edge-detect cycle and the debounce window.
- R7: `wakePulse` is high for exactly one cycle: the cycle in which `pdReq` rises at the end of a debounce. It never pulses on an open request.
- R8: If `rxPin` returns low before the debounce window ends, the wake-up is cancelled. A fresh rising edge is then needed, and a full window is timed from that edge.
- R9: `closeReq` in the running state runs the R3 power-down order but does not arm wake-up. `closeReq` while waiting for or timing a wake-up cancels it. In both cases a later rising edge on `rxPin` leaves `pdReq` low.
- R10: When `closeReq` and `breakDet` arrive in the same running cycle, the close wins and wake-up is not armed.
- R11: `breakDet` and `busyDet` have no effect outside the running state. `openReq` has no effect outside the off state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| openReq | input | 1 | Host request to power the UART up |
| closeReq | input | 1 | Host request to power the UART down without wake-up |
| breakDet | input | 1 | Break condition flagged by the UART receiver |
| busyDet | input | 1 | Busy-detect condition flagged by the UART |
| rxPin | input | 1 | Raw level of the RX pin (asynchronous) |
| pdReq | output | 1 | Request for the communication power domain |
| clkEn | output | 1 | UART clock enable |
| uartRst | output | 3 | Resets: bit 0 core, bit 1 RX FIFO, bit 2 TX FIFO |
| rxMuxUart | output | 1 | 1 routes RX to the UART, 0 keeps it a plain input |
| cfgBusy | output | 1 | UART reprogramming window |
| active | output | 1 | UART is in service (running or still shutting down) |
| wakePulse | output | 1 | One-cycle pulse when a debounced wake-up completes |

## Verification
A wrong state shows up at once on the output vector, because every output is decoded directly from the state register. A skipped or reordered step is therefore visible in the cycle it happens. A stepped table compares each cycle of power-up and power-down with the expected vector. A lost or wrongly set wake-arm flag only shows later, when the pin rises: `pdReq` either rises when it should stay low, or never rises. Counter faults show as a wake-up latency different from DEBOUNCE+3 edges, or a reprogramming window that is not CFG_CYCLES long.

// File: rtl/rxidle_pkg.sv
package rxidle_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_PU_PD,
    ST_PU_CLK,
    ST_PU_RST,
    ST_PU_CFG,
    ST_RUN,
    ST_SD_RST,
    ST_SD_CLKOFF,
    ST_SD_PDOFF,
    ST_WAIT_RISE,
    ST_DEBOUNCE
  } pwrState_t;

  // Strobes from control to datapath: load the shared down-counter.
  typedef struct packed {
    logic debLoad;
    logic cfgLoad;
  } dpStrobe_t;

  // uartRst bit order: [0] core, [1] RX FIFO, [2] TX FIFO.
  localparam logic [2:0] RST_ALL  = 3'b111;
  localparam logic [2:0] RST_NONE = 3'b000;

endpackage

// File: rtl/rxidle_dp.sv
module rxidle_dp
  import rxidle_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int DEB_CYCLES = 100,
  parameter int CFG_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxPin,
  input  dpStrobe_t strobe,
  output logic      rxRise,
  output logic      rxHigh,
  output logic      cntZero
);

  localparam logic [CNT_W-1:0] DEB_LOAD = CNT_W'(DEB_CYCLES - 1);
  localparam logic [CNT_W-1:0] CFG_LOAD = CNT_W'(CFG_CYCLES - 1);

  logic [1:0]       rxSync;
  logic             rxPrev;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync <= 2'b00;
      rxPrev <= 1'b0;
    end else begin
      rxSync <= {rxSync[0], rxPin};
      rxPrev <= rxSync[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.debLoad) begin
      cnt <= DEB_LOAD;
    end else if (strobe.cfgLoad) begin
      cnt <= CFG_LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign rxHigh  = rxSync[1];
  assign rxRise  = rxSync[1] & ~rxPrev;
  assign cntZero = (cnt == '0);

  // R6: the two loads come from different control states and never coincide
  a_r6_single_load: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.debLoad && strobe.cfgLoad));

  // R6: the debounce load always starts the full window
  a_r6_deb_window: assert property (@(posedge clk) disable iff (!rstN)
    strobe.debLoad |=> cnt == DEB_LOAD);

endmodule

// File: rtl/rxidle_ctrl.sv
module rxidle_ctrl
  import rxidle_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       openReq,
  input  logic       closeReq,
  input  logic       breakDet,
  input  logic       busyDet,
  input  logic       rxRise,
  input  logic       rxHigh,
  input  logic       cntZero,
  output dpStrobe_t  strobe,
  output logic       pdReq,
  output logic       clkEn,
  output logic [2:0] uartRst,
  output logic       rxMuxUart,
  output logic       cfgBusy,
  output logic       active,
  output logic       wakePulse
);

  pwrState_t state, nextState;
  logic      wakeArm, nextArm, wakeHit;

  always_comb begin
    nextState = state;
    nextArm   = wakeArm;
    strobe    = '0;
    case (state)
      ST_OFF:       if (openReq) nextState = ST_PU_PD;
      ST_PU_PD:     nextState = ST_PU_CLK;
      ST_PU_CLK:    nextState = ST_PU_RST;
      ST_PU_RST: begin
        nextState      = ST_PU_CFG;
        strobe.cfgLoad = 1'b1;
      end
      ST_PU_CFG:    if (cntZero) nextState = ST_RUN;
      ST_RUN: begin
        if (closeReq) begin
          nextState = ST_SD_RST;
          nextArm   = 1'b0;
        end else if (breakDet || busyDet) begin
          nextState = ST_SD_RST;
          nextArm   = 1'b1;
        end
      end
      ST_SD_RST:    nextState = ST_SD_CLKOFF;
      ST_SD_CLKOFF: nextState = ST_SD_PDOFF;
      ST_SD_PDOFF:  nextState = wakeArm ? ST_WAIT_RISE : ST_OFF;
      ST_WAIT_RISE: begin
        if (closeReq) begin
          nextState = ST_OFF;
          nextArm   = 1'b0;
        end else if (rxRise) begin
          nextState      = ST_DEBOUNCE;
          strobe.debLoad = 1'b1;
        end
      end
      ST_DEBOUNCE: begin
        if (closeReq) begin
          nextState = ST_OFF;
          nextArm   = 1'b0;
        end else if (!rxHigh) begin
          nextState = ST_WAIT_RISE;
        end else if (cntZero) begin
          nextState = ST_PU_PD;
        end
      end
      default:      nextState = ST_OFF;
    endcase
  end

  assign wakeHit = (state == ST_DEBOUNCE) && !closeReq && rxHigh && cntZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_OFF;
      wakeArm   <= 1'b0;
      wakePulse <= 1'b0;
    end else begin
      state     <= nextState;
      wakeArm   <= nextArm;
      wakePulse <= wakeHit;
    end
  end

  // Moore decode of the port values
  always_comb begin
    pdReq     = 1'b0;
    clkEn     = 1'b0;
    uartRst   = RST_NONE;
    rxMuxUart = 1'b0;
    cfgBusy   = 1'b0;
    active    = 1'b0;
    case (state)
      ST_PU_PD:     pdReq = 1'b1;
      ST_PU_CLK:    begin pdReq = 1'b1; clkEn = 1'b1; end
      ST_PU_RST:    begin pdReq = 1'b1; clkEn = 1'b1; uartRst = RST_ALL; end
      ST_PU_CFG:    begin pdReq = 1'b1; clkEn = 1'b1; cfgBusy = 1'b1; end
      ST_RUN:       begin pdReq = 1'b1; clkEn = 1'b1; rxMuxUart = 1'b1; active = 1'b1; end
      ST_SD_RST:    begin pdReq = 1'b1; clkEn = 1'b1; uartRst = RST_ALL; active = 1'b1; end
      ST_SD_CLKOFF: begin pdReq = 1'b1; uartRst = RST_ALL; active = 1'b1; end
      default:      ;
    endcase
  end

  // R2: the clock is never enabled without the power domain
  a_r2_clk_needs_pd: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |-> pdReq);

  // R3: the clock is removed only while all three resets are held
  a_r3_rst_at_clkoff: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkEn) |-> uartRst == RST_ALL);

  // R3: power is released only after the clock is already off
  a_r3_pd_after_clk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pdReq) |-> !$past(clkEn));

  // R3: active drops together with the power request
  a_r3_active_with_pd: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> $fell(pdReq));

  // R5: the pin belongs to the UART only while active
  a_r5_mux_when_active: assert property (@(posedge clk) disable iff (!rstN)
    rxMuxUart |-> active);

  // R7: the wake pulse lasts a single cycle and marks the power request
  a_r7_wake_single: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);
  a_r7_wake_with_pd: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> $rose(pdReq));

  // R11: without an open request the off state is kept
  a_r11_off_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && !openReq) |=> state == ST_OFF);

endmodule

// File: rtl/rxidle_pwrgate.sv
module rxidle_pwrgate
  import rxidle_pkg::*;
#(
  parameter int CLK_KHZ     = 32000,
  parameter int DEBOUNCE_MS = 100,
  parameter int CFG_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       openReq,
  input  logic       closeReq,
  input  logic       breakDet,
  input  logic       busyDet,
  input  logic       rxPin,
  output logic       pdReq,
  output logic       clkEn,
  output logic [2:0] uartRst,
  output logic       rxMuxUart,
  output logic       cfgBusy,
  output logic       active,
  output logic       wakePulse
);

  localparam int DEB_CYCLES = CLK_KHZ * DEBOUNCE_MS;
  localparam int MAX_LOAD   = (DEB_CYCLES > CFG_CYCLES) ? DEB_CYCLES : CFG_CYCLES;
  localparam int CNT_W      = $clog2(MAX_LOAD + 1);

  dpStrobe_t strobe;
  logic      rxRise, rxHigh, cntZero;

  rxidle_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .openReq   (openReq),
    .closeReq  (closeReq),
    .breakDet  (breakDet),
    .busyDet   (busyDet),
    .rxRise    (rxRise),
    .rxHigh    (rxHigh),
    .cntZero   (cntZero),
    .strobe    (strobe),
    .pdReq     (pdReq),
    .clkEn     (clkEn),
    .uartRst   (uartRst),
    .rxMuxUart (rxMuxUart),
    .cfgBusy   (cfgBusy),
    .active    (active),
    .wakePulse (wakePulse)
  );

  rxidle_dp #(
    .CNT_W      (CNT_W),
    .DEB_CYCLES (DEB_CYCLES),
    .CFG_CYCLES (CFG_CYCLES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .rxPin   (rxPin),
    .strobe  (strobe),
    .rxRise  (rxRise),
    .rxHigh  (rxHigh),
    .cntZero (cntZero)
  );

endmodule

// File: tb/rxidle_pwrgate_bench.sv
module rxidle_pwrgate_bench;

  localparam int CLK_KHZ     = 1;
  localparam int DEBOUNCE_MS = 20;
  localparam int CFG_CYCLES  = 4;
  localparam int DEB         = CLK_KHZ * DEBOUNCE_MS;
  localparam int WAKE_EDGES  = DEB + 3;

  // {open, close, break, busy, pd, clk, rst[2:0], mux, active, cfg}
  localparam logic [11:0] SEQ [12] = '{
    12'h880, 12'h0C0, 12'h0F8, 12'h0C1, 12'h0C1, 12'h0C1,
    12'h0C1, 12'h0C6, 12'h2FA, 12'h0BA, 12'h000, 12'h000
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic openReq = 1'b0, closeReq = 1'b0, breakDet = 1'b0, busyDet = 1'b0, rxPin = 1'b0;
  logic pdReq, clkEn, rxMuxUart, cfgBusy, active, wakePulse;
  logic [2:0] uartRst;
  int nChecks = 0;
  int nFail = 0;
  int n;

  always #5 clk = ~clk;

  rxidle_pwrgate #(
    .CLK_KHZ(CLK_KHZ), .DEBOUNCE_MS(DEBOUNCE_MS), .CFG_CYCLES(CFG_CYCLES)
  ) u_rxidle_pwrgate (
    .clk(clk), .rstN(rstN), .openReq(openReq), .closeReq(closeReq),
    .breakDet(breakDet), .busyDet(busyDet), .rxPin(rxPin),
    .pdReq(pdReq), .clkEn(clkEn), .uartRst(uartRst), .rxMuxUart(rxMuxUart),
    .cfgBusy(cfgBusy), .active(active), .wakePulse(wakePulse)
  );

  function automatic logic [7:0] outVec();
    return {pdReq, clkEn, uartRst, rxMuxUart, active, cfgBusy};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clock edge; inputs held across it, results sampled at the next negedge.
  task automatic cyc(input logic o, input logic c, input logic b, input logic u);
    openReq = o; closeReq = c; breakDet = b; busyDet = u;
    @(posedge clk);
    @(negedge clk);
    openReq = 1'b0; closeReq = 1'b0; breakDet = 1'b0; busyDet = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic countToPd(output int edges);
    edges = 0;
    while (!pdReq && edges < 200) begin
      cyc(1'b0, 1'b0, 1'b0, 1'b0);
      edges++;
    end
  endtask

  task automatic bringUp();
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    idle(3 + CFG_CYCLES);
  endtask

  task automatic expectNoWake(input string tag);
    int seen = 0;
    rxPin = 1'b1;
    for (int i = 0; i < DEB + 10; i++) begin
      cyc(1'b0, 1'b0, 1'b0, 1'b0);
      if (pdReq || wakePulse) seen++;
    end
    chk(tag, seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 outputs in reset", {outVec(), wakePulse}, 9'h000);
    @(negedge clk);
    rstN = 1'b1;
    idle(2);
    chk("R1 outputs after reset", {outVec(), wakePulse}, 9'h000);

    // R11: break and busy in the off state change nothing
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    idle(2);
    chk("R11 break/busy ignored while off", outVec(), 8'h00);

    // R2 power-up then R3 break power-down, one row per edge
    for (int i = 0; i < 12; i++) begin
      cyc(SEQ[i][11], SEQ[i][10], SEQ[i][9], SEQ[i][8]);
      chk(i < 8 ? "R2 power-up step" : "R3 power-down step", outVec(), SEQ[i][7:0]);
      chk("R7 no wake pulse on open", wakePulse, 1'b0);
      if (i == 7) chk("R5 pin to UART in run", rxMuxUart, 1'b1);
      if (i == 8) chk("R5 pin to input on shutdown", rxMuxUart, 1'b0);
    end

    // R6 wake-up latency and R7 pulse
    rxPin = 1'b1;
    countToPd(n);
    chk("R6 wake edges", n, WAKE_EDGES);
    chk("R7 pulse with pd", wakePulse, 1'b1);
    chk("R6 pd alone first", outVec(), 8'h80);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 pulse one cycle", wakePulse, 1'b0);
    idle(2 + CFG_CYCLES);
    chk("R2 running after wake", outVec(), 8'hC6);

    // R11: open while running has no effect
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R11 open ignored in run", outVec(), 8'hC6);

    // R4 busy power-down, then R8 glitch cancel and restart
    rxPin = 1'b0;
    idle(3);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R4 busy reset step", outVec(), 8'hFA);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 busy clock off", outVec(), 8'hBA);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 busy power off", outVec(), 8'h00);
    idle(1);
    rxPin = 1'b1;
    idle(DEB / 2);
    rxPin = 1'b0;
    n = 0;
    for (int i = 0; i < DEB + 5; i++) begin
      cyc(1'b0, 1'b0, 1'b0, 1'b0);
      if (pdReq) n++;
    end
    chk("R8 low pulse cancels wake", n, 0);
    rxPin = 1'b1;
    countToPd(n);
    chk("R8 full window from new edge", n, WAKE_EDGES);
    idle(3 + CFG_CYCLES);
    chk("R2 running after second wake", active, 1'b1);

    // R9 close from run: same order, no wake
    rxPin = 1'b0;
    idle(3);
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 close reset step", outVec(), 8'hFA);
    idle(2);
    chk("R9 close powered off", outVec(), 8'h00);
    expectNoWake("R9 no wake after close");

    // R9 close while waiting for the edge disarms
    rxPin = 1'b0;
    bringUp();
    chk("R2 running via open", outVec(), 8'hC6);
    idle(3);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    idle(3);
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    expectNoWake("R9 close while waiting");

    // R9 close during the debounce window
    rxPin = 1'b0;
    bringUp();
    idle(3);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    idle(3);
    rxPin = 1'b1;
    idle(5);
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    n = 0;
    for (int i = 0; i < DEB + 10; i++) begin
      cyc(1'b0, 1'b0, 1'b0, 1'b0);
      if (pdReq) n++;
    end
    chk("R9 close during debounce", n, 0);

    // R10 close beats break in the same cycle
    rxPin = 1'b0;
    bringUp();
    idle(3);
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    idle(3);
    expectNoWake("R10 close wins over break");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule